// File: doc/BRIEF.md
# Unarbitrated Pixel Event Verifier

This block sits at the edge of a pixel matrix whose fired pixels are not arbitrated. Every fired pixel pulls its own row request line and its own column request line, and those lines are wired-OR across the matrix. The readout therefore receives only a row bitmask and a column bitmask. Once two or more pixels in different rows and columns fire, the crossings of those masks also name pixels that stayed quiet. The verifier takes one pair of masks when it is idle and treats every crossing of a set row bit with a set column bit as a candidate. It asks the matrix about each candidate through a query/response port and keeps only the pixels that answer as fired.

Each confirmed pixel leaves the block as two entries written in the same cycle: its address goes into an address queue and its timestamp goes into a timestamp queue. The timestamp is the time-to-digital count present when the masks were taken, and one value serves every pixel from that pair of masks. A pair of masks with exactly one bit set in each is unambiguous, so that pixel is accepted without a query. The block reports `busy` while a pair of masks is being resolved. If either queue lacks room, querying pauses, so no confirmed event is lost.

Top module: `aer_verifier`

## Requirements
- R1: After reset `busy` and `poll_req` are 0, and `addr_empty` and `ts_empty` are 1.
- R2: `mask_valid` is taken only while `busy` is 0. Masks offered while `busy` is 1 produce no query and no queue entry.
- R3: Candidates are the pairs (r,c) with `row_mask[r]` and `col_mask[c]` both 1, where bit i of each mask stands for row or column i. They are queried in ascending order of r*COLS+c, with at most one `poll_req` per cycle. Every candidate is queried exactly once, and `poll_req` is 1 only while `busy` is 1.
- R4: `poll_hit` is the answer to the query one cycle earlier. A 1 pushes the address {row index, column index} (row in the upper bits) and the timestamp into their queues in the same cycle. A 0 pushes nothing.
- R5: Every event from one pair of masks carries the `ts_count` value seen in the cycle the masks were taken, even if `ts_count` changes later.
- R6: When both masks have exactly one bit set, no `poll_req` is issued and that single pixel is queued regardless of the matrix state.
- R7: A query is issued only if both queues can absorb its answer. When they cannot, `poll_req` stays 0 and `busy` stays 1, and all confirmed events arrive later, complete and in order.
- R8: `busy` falls in the cycle after the last answer is handled. A pair of masks with no candidate keeps `busy` high for exactly one cycle.
- R9: The queues deliver entries in push order. `addr_pop` and `ts_pop` remove the head, and a pop while a queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_valid | input | 1 | Offer of a row/column mask pair |
| row_mask | input | ROWS | OR of row request lines |
| col_mask | input | COLS | OR of column request lines |
| ts_count | input | TS_W | Running time-to-digital count |
| busy | output | 1 | A mask pair is being resolved |
| poll_req | output | 1 | Query for one candidate pixel |
| poll_row | output | clog2(ROWS) | Row index of the query |
| poll_col | output | clog2(COLS) | Column index of the query |
| poll_hit | input | 1 | Answer: queried pixel fired (one cycle after query) |
| addr_pop | input | 1 | Remove head of address queue |
| addr_empty | output | 1 | Address queue empty |
| addr_data | output | clog2(ROWS)+clog2(COLS) | Head of address queue |
| ts_pop | input | 1 | Remove head of timestamp queue |
| ts_empty | output | 1 | Timestamp queue empty |
| ts_data | output | TS_W | Head of timestamp queue |

## Verification
A corrupted remaining-candidate mask shows up on the very next `poll_req` as a row/column pair out of ascending order, or as a skipped or repeated candidate. The bench checks each query against its own expected list in the cycle it appears. A wrong held timestamp or a lost answer appears at the queue heads as soon as the affected event is popped, and a mistaken room check shows up as extra queries past the queue depth while nothing is being popped. A stuck state register shows up as `busy` failing to fall one cycle after the last answer.

// File: rtl/aer_verifier_pkg.sv
package aer_verifier_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;

endpackage

// File: rtl/cand_picker.sv
module cand_picker #(
  parameter int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/evt_fifo.sv
module evt_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [W-1:0]    din,
  input  logic            pop,
  output logic [W-1:0]    dout,
  output logic            empty,
  output logic            full,
  output logic [CNTW-1:0] count
);

  logic [W-1:0]    mem [DEPTH];
  logic [PW-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNTW'(DEPTH));
  assign count   = cnt_q;
  assign dout    = mem[rd_q];
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_ok) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop_ok)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/aer_verifier.sv
module aer_verifier
  import aer_verifier_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int TS_W  = 8,
  parameter int DEPTH = 4,
  localparam int RW   = $clog2(ROWS),
  localparam int CLW  = $clog2(COLS),
  localparam int AW   = RW + CLW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_valid,
  input  logic [ROWS-1:0] row_mask,
  input  logic [COLS-1:0] col_mask,
  input  logic [TS_W-1:0] ts_count,
  output logic            busy,
  output logic            poll_req,
  output logic [RW-1:0]   poll_row,
  output logic [CLW-1:0]  poll_col,
  input  logic            poll_hit,
  input  logic            addr_pop,
  output logic            addr_empty,
  output logic [AW-1:0]   addr_data,
  input  logic            ts_pop,
  output logic            ts_empty,
  output logic [TS_W-1:0] ts_data
);

  localparam int NCAND = ROWS * COLS;
  localparam int IW    = $clog2(NCAND);
  localparam int CNTW  = $clog2(DEPTH + 1);

  scan_state_e      state_q, state_d;
  logic [NCAND-1:0] rem_q, rem_d;
  logic [NCAND-1:0] cand_w;
  logic [TS_W-1:0]  ts_q;
  logic             single_q;
  logic             pend_q;
  logic [RW-1:0]    pend_row_q;
  logic [CLW-1:0]   pend_col_q;

  logic             pick_any;
  logic [IW-1:0]    pick_idx;
  logic [RW-1:0]    pick_row;
  logic [CLW-1:0]   pick_col;

  logic             capture, issue, done, room, evt_push;
  logic             a_full, t_full;
  logic [CNTW-1:0]  a_cnt, t_cnt;
  logic [CNTW:0]    a_need, t_need;

  // candidate map: one bit per row/column crossing, row-major
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign cand_w[r*COLS + c] = row_mask[r] & col_mask[c];
    end
  end

  cand_picker #(.N(NCAND)) u_pick (
    .vec (rem_q),
    .any (pick_any),
    .idx (pick_idx)
  );

  assign pick_row = RW'(pick_idx / IW'(COLS));
  assign pick_col = CLW'(pick_idx % IW'(COLS));

  // room for the answer in flight plus the one about to be asked
  assign a_need = {1'b0, a_cnt} + {{CNTW{1'b0}}, pend_q};
  assign t_need = {1'b0, t_cnt} + {{CNTW{1'b0}}, pend_q};
  assign room   = (a_need < (CNTW+1)'(DEPTH)) && (t_need < (CNTW+1)'(DEPTH));

  assign capture  = (state_q == ST_IDLE) && mask_valid;
  assign issue    = (state_q == ST_SCAN) && pick_any && room;
  assign done     = (state_q == ST_SCAN) && !pick_any && !pend_q;
  assign evt_push = pend_q && (single_q || poll_hit);

  assign busy     = (state_q != ST_IDLE);
  assign poll_req = issue && !single_q;
  assign poll_row = pick_row;
  assign poll_col = pick_col;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    case (state_q)
      ST_IDLE: if (capture) begin
        state_d = ST_SCAN;
        rem_d   = cand_w;
      end
      ST_SCAN: begin
        if (issue) rem_d = rem_q & ~(NCAND'(1) << pick_idx);
        if (done)  state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      rem_q      <= '0;
      ts_q       <= '0;
      single_q   <= 1'b0;
      pend_q     <= 1'b0;
      pend_row_q <= '0;
      pend_col_q <= '0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      pend_q  <= issue;
      if (capture) begin
        ts_q     <= ts_count;
        single_q <= $onehot(row_mask) && $onehot(col_mask);
      end
      if (issue) begin
        pend_row_q <= pick_row;
        pend_col_q <= pick_col;
      end
    end
  end

  evt_fifo #(.W(AW), .DEPTH(DEPTH)) u_addr_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (evt_push),
    .din   ({pend_row_q, pend_col_q}),
    .pop   (addr_pop),
    .dout  (addr_data),
    .empty (addr_empty),
    .full  (a_full),
    .count (a_cnt)
  );

  evt_fifo #(.W(TS_W), .DEPTH(DEPTH)) u_ts_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (evt_push),
    .din   (ts_q),
    .pop   (ts_pop),
    .dout  (ts_data),
    .empty (ts_empty),
    .full  (t_full),
    .count (t_cnt)
  );

endmodule

// File: rtl/aer_verifier_chk.sv
module aer_verifier_chk #(
  parameter int TS_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            poll_req,
  input logic            evt_push,
  input logic            a_full,
  input logic            t_full,
  input logic [TS_W-1:0] ts_hold,
  input logic            single,
  input logic            addr_empty
);

  // R3: queries only while a mask pair is being resolved
  p_req_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req |-> busy);

  // R7: no push ever meets a full queue
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_push |-> (!a_full && !t_full));

  // R5: held timestamp does not move while resolving
  p_ts_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ts_hold));

  // R6: an unambiguous pair issues no query
  p_single_nopoll_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && single) |-> !poll_req);

  // R9: an empty queue without a push stays empty, whatever is popped
  p_empty_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_empty && !evt_push) |=> addr_empty);

endmodule

bind aer_verifier aer_verifier_chk #(.TS_W(TS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .poll_req   (poll_req),
  .evt_push   (evt_push),
  .a_full     (a_full),
  .t_full     (t_full),
  .ts_hold    (ts_q),
  .single     (single_q),
  .addr_empty (addr_empty)
);

// File: tb/test_aer_verifier.sv
`timescale 1ns/1ps
module test_aer_verifier;

  localparam int ROWS  = 4;
  localparam int COLS  = 4;
  localparam int TS_W  = 8;
  localparam int DEPTH = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            mask_valid = 1'b0;
  logic [ROWS-1:0] row_mask = '0;
  logic [COLS-1:0] col_mask = '0;
  logic [TS_W-1:0] ts_count = '0;
  logic            busy, poll_req, poll_hit;
  logic [1:0]      poll_row, poll_col;
  logic            addr_pop = 1'b0, ts_pop = 1'b0;
  logic            addr_empty, ts_empty;
  logic [3:0]      addr_data;
  logic [TS_W-1:0] ts_data;

  logic [ROWS-1:0][COLS-1:0] fired = '0;
  logic hit_r;

  int total = 0, bad = 0, npoll = 0;
  int cand_q[$], exp_a[$], exp_t[$];
  bit finished = 0;

  always #2 clk = ~clk;

  aer_verifier #(.ROWS(ROWS), .COLS(COLS), .TS_W(TS_W), .DEPTH(DEPTH)) i_aer_verifier (
    .clk(clk), .rst_n(rst_n), .mask_valid(mask_valid), .row_mask(row_mask),
    .col_mask(col_mask), .ts_count(ts_count), .busy(busy), .poll_req(poll_req),
    .poll_row(poll_row), .poll_col(poll_col), .poll_hit(poll_hit),
    .addr_pop(addr_pop), .addr_empty(addr_empty), .addr_data(addr_data),
    .ts_pop(ts_pop), .ts_empty(ts_empty), .ts_data(ts_data)
  );

  // matrix model: answers one cycle after the query
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_r <= 1'b0;
    else        hit_r <= poll_req && fired[poll_row][poll_col];
  end
  assign poll_hit = hit_r;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // every clock: compare each query against the expected candidate list
  always @(negedge clk) begin
    if (rst_n && poll_req) begin
      int e;
      npoll++;
      if (cand_q.size() == 0) begin
        chk(0, "R3 query with no candidate left", int'(poll_row)*COLS + int'(poll_col), -1);
      end else begin
        e = cand_q.pop_front();
        chk(int'(poll_row)*COLS + int'(poll_col) == e, "R3 query order",
            int'(poll_row)*COLS + int'(poll_col), e);
      end
    end
  end

  task automatic send(input logic [3:0] rm, input logic [3:0] cm, input logic [7:0] ts);
    bit single;
    int guard = 0;
    while (busy && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    single = $onehot(rm) && $onehot(cm);
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        if (rm[r] && cm[c]) begin
          if (!single) cand_q.push_back(r*COLS + c);
          if (single || fired[r][c]) begin
            exp_a.push_back(r*COLS + c);
            exp_t.push_back(int'(ts));
          end
        end
      end
    end
    row_mask   = rm;
    col_mask   = cm;
    ts_count   = ts;
    mask_valid = 1'b1;
    @(negedge clk);
    mask_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    int guard = 0;
    while ((busy || !addr_empty) && guard < 2000) begin
      addr_pop = 1'b0;
      ts_pop   = 1'b0;
      if (!addr_empty) begin
        if (exp_a.size() == 0) begin
          chk(0, {req, " unexpected event"}, int'(addr_data), -1);
        end else begin
          int ea = exp_a.pop_front();
          int et = exp_t.pop_front();
          chk(int'(addr_data) == ea, {req, " address"}, int'(addr_data), ea);
          chk(int'(ts_data) == et, "R5 timestamp", int'(ts_data), et);
        end
        addr_pop = 1'b1;
        ts_pop   = 1'b1;
      end
      @(negedge clk);
      guard++;
    end
    addr_pop = 1'b0;
    ts_pop   = 1'b0;
    chk(exp_a.size() == 0, {req, " all events delivered"}, exp_a.size(), 0);
    chk(cand_q.size() == 0, "R3 every candidate queried", cand_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    // R1 during and after reset
    chk(busy == 0 && poll_req == 0, "R1 outputs idle in reset", {busy, poll_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(addr_empty && ts_empty, "R1 queues empty after reset", {addr_empty, ts_empty}, 3);

    // R3 R4: (1,1) and (3,3) fired, two phantom crossings rejected
    fired = '0;
    fired[1][1] = 1'b1;
    fired[3][3] = 1'b1;
    npoll = 0;
    send(4'b1010, 4'b1010, 8'h21);
    ts_count = 8'h99;  // R5: later change must not leak into events
    drain("R4 phantom rejection");
    chk(npoll == 4, "R3 query count for 2x2 crossings", npoll, 4);

    // R4 another pattern: rows 1,2 x cols 0,3, true (1,3) and (2,0)
    fired = '0;
    fired[1][3] = 1'b1;
    fired[2][0] = 1'b1;
    send(4'b0110, 4'b1001, 8'h44);
    ts_count = 8'h01;
    drain("R4 mixed pattern");

    // R6: unambiguous pair, matrix reports nothing, still queued unqueried
    fired = '0;
    snap = npoll;
    send(4'b0100, 4'b0001, 8'h33);
    drain("R6 single candidate");
    chk(npoll == snap, "R6 no query for single candidate", npoll - snap, 0);

    // R8: no candidate, busy high exactly one cycle
    send(4'b0000, 4'b1111, 8'h10);
    chk(busy == 1, "R8 busy after empty capture", busy, 1);
    @(negedge clk);
    chk(busy == 0, "R8 busy falls after one cycle", busy, 0);
    chk(addr_empty, "R8 no event from empty mask", addr_empty, 1);

    // R7: all 16 fired, no pops: querying stops at queue depth
    fired = '1;
    npoll = 0;
    send(4'hF, 4'hF, 8'h55);
    repeat (30) @(negedge clk);
    chk(npoll == DEPTH, "R7 queries stop when queues full", npoll, DEPTH);
    chk(busy == 1 && poll_req == 0, "R7 stalled and still busy", {busy, poll_req}, 2);
    // R2: an offer while busy is ignored
    row_mask   = 4'b0001;
    col_mask   = 4'b0001;
    ts_count   = 8'hEE;
    mask_valid = 1'b1;
    @(negedge clk);
    mask_valid = 1'b0;
    drain("R7 no event lost after stall");
    chk(addr_empty && !busy, "R2 offer while busy produced nothing", addr_empty, 1);

    // R9: pops on empty queues have no effect
    addr_pop = 1'b1;
    ts_pop   = 1'b1;
    repeat (2) @(negedge clk);
    addr_pop = 1'b0;
    ts_pop   = 1'b0;
    chk(addr_empty && ts_empty, "R9 empty after popping empty", {addr_empty, ts_empty}, 3);
    fired = '0;
    send(4'b0010, 4'b1000, 8'h77);
    repeat (3) @(negedge clk);
    chk(!addr_empty && !ts_empty, "R9 single entry visible after empty pops",
        {addr_empty, ts_empty}, 0);
    drain("R9 entry after empty pops");
    chk(addr_empty && ts_empty, "R9 queues empty after one pop", {addr_empty, ts_empty}, 3);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule